// File: doc/BRIEF.md
# Dual-Port Pixel Serialiser with Colour Lookup and Palette Match

This block sits between a frame-buffer read path and a video DAC. On every load strobe it captures a pair of 24-bit pixels from two input ports, A and B. Each pixel comes with two palette-select bits, a sync bit and a blank bit. In pair mode it sends the pair out one pixel per clock, A first, so the load strobe fires on every second clock. In single mode it takes a pixel from port A on every clock and ignores port B.

Each pixel is turned into three 8-bit table indices, according to the selected format: 24-bit direct, 15-bit direct or 8-bit indexed. The indices are masked and then look up three 256-entry tables of 10-bit words, one table per colour. The 30-bit result appears after a fixed latency. The colour is forced to zero when the pixel is blanked or when its palette-select bits differ from the programmed match value. The sync bit follows the same pipeline to a delayed sync output. A separate flag carries sync for the video level, and only when that encoding is enabled. All mode inputs are static while out of reset. The tables are loaded through a simple write port.

Top module: `pixel_port_clut`

## Requirements
- R1: `load_strobe` is high on every clock when `mux2_en`=0. When `mux2_en`=1 it is high on the first clock after reset and then on every second clock. Port inputs are captured at each rising edge where `load_strobe` is high.
- R2: Counting the capture edge as 0, pixel A of a capture appears on the outputs after edge 5 in single mode and after edge 6 in pair mode. In pair mode pixel B follows one edge later.
- R3: With `fmt`=0 (24-bit direct; code 3 acts the same), red, green and blue each index their own table. The tables are red, green and blue for `lut_sel` 0, 1 and 2.
- R4: With `fmt`=1 (15-bit direct), each table index is the top five bits of that colour's 8-bit input, followed by three zero bits.
- R5: With `fmt`=2 (8-bit indexed), one index addresses all three tables. `pseudo_src` selects the port field that supplies it: 0 selects red, 1 green, and 2 or 3 blue.
- R6: Every table index is ANDed with `pix_mask` before the lookup.
- R7: A pixel whose palette-select bits differ from `ps_match` gives a colour of zero.
- R8: A pixel whose blank bit is 1 gives a colour of zero, whatever the tables hold.
- R9: `sync_out` is the pixel's sync bit at the same latency as its colour. Blank, palette match and `sync_en` have no effect on it.
- R10: `sync_lvl` equals `sync_out` when `sync_en`=1 and is 0 when `sync_en`=0.
- R11: While `rst_n` is low, all colour outputs, `sync_out` and `sync_lvl` are 0 and `load_strobe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux2_en | input | 1 | 1 = pair mode (A then B), 0 = single mode (port A only) |
| fmt | input | 2 | Pixel format: 0/3 24-bit, 1 15-bit, 2 indexed |
| pseudo_src | input | 2 | Index source in indexed mode |
| ps_match | input | 2 | Palette-select value that enables a pixel |
| sync_en | input | 1 | Enables sync on the video level flag |
| pix_mask | input | 8 | AND mask applied to each table index |
| a_r | input | 8 | Port A red |
| a_g | input | 8 | Port A green |
| a_b | input | 8 | Port A blue |
| a_ps | input | 2 | Port A palette select |
| a_sync | input | 1 | Port A sync |
| a_blank | input | 1 | Port A blank |
| b_r | input | 8 | Port B red |
| b_g | input | 8 | Port B green |
| b_b | input | 8 | Port B blue |
| b_ps | input | 2 | Port B palette select |
| b_sync | input | 1 | Port B sync |
| b_blank | input | 1 | Port B blank |
| load_strobe | output | 1 | High in the cycle whose rising edge captures the ports |
| lut_we | input | 1 | Table write enable |
| lut_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| lut_addr | input | 8 | Table write address |
| lut_wdata | input | 10 | Table write data |
| out_r | output | 10 | Red colour word |
| out_g | output | 10 | Green colour word |
| out_b | output | 10 | Blue colour word |
| sync_out | output | 1 | Delayed sync |
| sync_lvl | output | 1 | Sync for the video level |

## Verification
Colour and sync for pixel A are due five edges after the capture edge in single mode and six in pair mode, and pixel B is due one edge after A. The bench numbers every clock edge from reset release. At each capture it stores the model's results in a ring slot keyed by the due edge number. It compares the outputs half a cycle after that edge, so every check lands on the exact cycle that R2 sets. The load strobe is checked every cycle against the edge parity, and the reset values are checked while reset is held.

// File: rtl/pixport_pkg.sv
`timescale 1ns/1ps
package pixport_pkg;
    localparam int CW    = 8;          // colour component / index width
    localparam int DW    = 10;         // table word width
    localparam int PSW   = 2;          // palette-select width
    localparam int FW    = 5;          // 15-bit format field width
    localparam int NCH   = 3;          // colour channels
    localparam int DEPTH = 1 << CW;    // table depth

    typedef enum logic [1:0] {
        FMT_DIRECT24 = 2'd0,
        FMT_DIRECT15 = 2'd1,
        FMT_INDEXED  = 2'd2,
        FMT_SPARE    = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [CW-1:0]  r;
        logic [CW-1:0]  g;
        logic [CW-1:0]  b;
        logic [PSW-1:0] ps;
        logic           sync;
        logic           blank;
    } pix_t;

    typedef struct packed {
        logic vld;
        pix_t a;
        pix_t b;
    } pair_t;

    typedef struct packed {
        logic vld;
        pix_t p;
    } spix_t;

    typedef struct packed {
        logic vld;
        logic hit;
        logic sync;
        logic blank;
    } flag_t;

    typedef logic [NCH-1:0][CW-1:0] idx_t;
    typedef logic [NCH-1:0][DW-1:0] col_t;

    typedef struct packed {
        col_t col;
        logic sync;
        logic slvl;
    } outw_t;
endpackage

// File: rtl/pixport_serializer.sv
`timescale 1ns/1ps
module pixport_serializer
    import pixport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mux2_en,
    input  pix_t  port_a,
    input  pix_t  port_b,
    output logic  load_strobe,
    output spix_t ser
);
    typedef struct packed {
        logic  ph;      // 1 = second half of a pair period
        pair_t cap;
        spix_t ser;
    } st_t;

    st_t st_d, st_q;

    assign load_strobe = ~mux2_en | ~st_q.ph;

    always_comb begin
        st_d    = st_q;
        st_d.ph = mux2_en ? ~st_q.ph : 1'b0;
        if (load_strobe) begin
            st_d.cap.vld = 1'b1;
            st_d.cap.a   = port_a;
            st_d.cap.b   = port_b;
        end
        // phase 1 follows a capture edge: emit A; phase 0: emit B
        st_d.ser.vld = st_q.cap.vld;
        st_d.ser.p   = (!mux2_en || st_q.ph) ? st_q.cap.a : st_q.cap.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser = st_q.ser;
endmodule

// File: rtl/pixport_index.sv
`timescale 1ns/1ps
module pixport_index
    import pixport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  spix_t          ser,
    input  logic [1:0]     fmt,
    input  logic [1:0]     pseudo_src,
    input  logic [PSW-1:0] ps_match,
    input  logic [CW-1:0]  pix_mask,
    output idx_t           idx,
    output flag_t          flg
);
    typedef struct packed {
        idx_t  idx;
        flag_t flg;
    } st_t;

    st_t  st_d, st_q;
    idx_t comp;
    idx_t raw;
    logic [CW-1:0] isel;

    always_comb begin
        comp[0] = ser.p.r;
        comp[1] = ser.p.g;
        comp[2] = ser.p.b;
        case (pseudo_src)
            2'd0:    isel = ser.p.r;
            2'd1:    isel = ser.p.g;
            default: isel = ser.p.b;
        endcase
        for (int c = 0; c < NCH; c++) begin
            case (fmt_e'(fmt))
                FMT_DIRECT15: raw[c] = {comp[c][CW-1 -: FW], {(CW-FW){1'b0}}};
                FMT_INDEXED:  raw[c] = isel;
                default:      raw[c] = comp[c];
            endcase
        end
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            st_d.idx[c] = raw[c] & pix_mask;
        end
        st_d.flg.vld   = ser.vld;
        st_d.flg.hit   = (ser.p.ps == ps_match);
        st_d.flg.sync  = ser.p.sync;
        st_d.flg.blank = ser.p.blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
    assign flg = st_q.flg;
endmodule

// File: rtl/pixport_clut.sv
`timescale 1ns/1ps
module pixport_clut
    import pixport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  idx_t          idx,
    output col_t          col
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [DW-1:0] mem [DEPTH];
        logic [DW-1:0] rd_d, rd_q;

        always_ff @(posedge clk) begin
            if (we && sel == 2'(c)) mem[waddr] <= wdata;
        end

        always_comb rd_d = mem[idx[c]];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_d;
        end

        assign col[c] = rd_q;
    end
endmodule

// File: rtl/pixel_port_clut.sv
`timescale 1ns/1ps
module pixel_port_clut
    import pixport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mux2_en,
    input  logic [1:0]     fmt,
    input  logic [1:0]     pseudo_src,
    input  logic [PSW-1:0] ps_match,
    input  logic           sync_en,
    input  logic [CW-1:0]  pix_mask,
    input  logic [CW-1:0]  a_r,
    input  logic [CW-1:0]  a_g,
    input  logic [CW-1:0]  a_b,
    input  logic [PSW-1:0] a_ps,
    input  logic           a_sync,
    input  logic           a_blank,
    input  logic [CW-1:0]  b_r,
    input  logic [CW-1:0]  b_g,
    input  logic [CW-1:0]  b_b,
    input  logic [PSW-1:0] b_ps,
    input  logic           b_sync,
    input  logic           b_blank,
    output logic           load_strobe,
    input  logic           lut_we,
    input  logic [1:0]     lut_sel,
    input  logic [CW-1:0]  lut_addr,
    input  logic [DW-1:0]  lut_wdata,
    output logic [DW-1:0]  out_r,
    output logic [DW-1:0]  out_g,
    output logic [DW-1:0]  out_b,
    output logic           sync_out,
    output logic           sync_lvl
);
    localparam int NTAP = 3;   // output stage plus two alignment stages

    pix_t  port_a, port_b;
    spix_t ser_w;
    idx_t  idx_w;
    flag_t flg_w;
    col_t  col_w;

    assign port_a = '{r: a_r, g: a_g, b: a_b, ps: a_ps, sync: a_sync, blank: a_blank};
    assign port_b = '{r: b_r, g: b_g, b: b_b, ps: b_ps, sync: b_sync, blank: b_blank};

    pixport_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux2_en     (mux2_en),
        .port_a      (port_a),
        .port_b      (port_b),
        .load_strobe (load_strobe),
        .ser         (ser_w)
    );

    pixport_index u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser        (ser_w),
        .fmt        (fmt),
        .pseudo_src (pseudo_src),
        .ps_match   (ps_match),
        .pix_mask   (pix_mask),
        .idx        (idx_w),
        .flg        (flg_w)
    );

    pixport_clut u_clut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lut_we),
        .sel   (lut_sel),
        .waddr (lut_addr),
        .wdata (lut_wdata),
        .idx   (idx_w),
        .col   (col_w)
    );

    typedef struct packed {
        flag_t                 fl;   // flags aligned with the table read
        outw_t [NTAP-1:0]      o;
    } st_t;

    st_t   st_d, st_q;
    outw_t sel_o;

    always_comb begin
        st_d       = st_q;
        st_d.fl    = flg_w;
        st_d.o[0].col  = (st_q.fl.vld && st_q.fl.hit && !st_q.fl.blank) ? col_w : '0;
        st_d.o[0].sync = st_q.fl.vld && st_q.fl.sync;
        st_d.o[0].slvl = st_q.fl.vld && st_q.fl.sync && sync_en;
        for (int t = 1; t < NTAP; t++) begin
            st_d.o[t] = st_q.o[t-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o    = mux2_en ? st_q.o[2] : st_q.o[1];
    assign out_r    = sel_o.col[0];
    assign out_g    = sel_o.col[1];
    assign out_b    = sel_o.col[2];
    assign sync_out = sel_o.sync;
    assign sync_lvl = sel_o.slvl;
endmodule

// File: rtl/pixport_checks.sv
`timescale 1ns/1ps
module pixport_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       mux2_en,
    input logic       sync_en,
    input logic [1:0] ps_match,
    input logic       load_strobe,
    input logic       ser_vld,
    input logic       ser_sync,
    input logic       ser_blank,
    input logic [1:0] ser_ps,
    input logic [9:0] out_r,
    input logic [9:0] out_g,
    input logic [9:0] out_b,
    input logic       sync_out,
    input logic       sync_lvl
);
    logic [2:0] warm_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end
    assign warm = (warm_q == 3'd7);

    wire col_zero = (out_r == '0) && (out_g == '0) && (out_b == '0);

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mux2_en |-> load_strobe);
    assert_strobe_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mux2_en && load_strobe) |=> !load_strobe);
    assert_strobe_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mux2_en && !load_strobe) |=> load_strobe);

    assert_sync_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !mux2_en) |-> (sync_out == $past(ser_vld && ser_sync, 4)));
    assert_sync_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && mux2_en) |-> (sync_out == $past(ser_vld && ser_sync, 5)));

    assert_blank_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !mux2_en && $past(ser_vld && ser_blank, 4)) |-> col_zero);
    assert_blank_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && mux2_en && $past(ser_vld && ser_blank, 5)) |-> col_zero);

    assert_psmiss_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !mux2_en && $past(ser_vld && (ser_ps != ps_match), 4)) |-> col_zero);
    assert_psmiss_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && mux2_en && $past(ser_vld && (ser_ps != ps_match), 5)) |-> col_zero);

    assert_lvl_needs_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lvl |-> sync_out);
    assert_lvl_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !sync_lvl);
endmodule

bind pixel_port_clut pixport_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux2_en     (mux2_en),
    .sync_en     (sync_en),
    .ps_match    (ps_match),
    .load_strobe (load_strobe),
    .ser_vld     (ser_w.vld),
    .ser_sync    (ser_w.p.sync),
    .ser_blank   (ser_w.p.blank),
    .ser_ps      (ser_w.p.ps),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b),
    .sync_out    (sync_out),
    .sync_lvl    (sync_lvl)
);

// File: tb/pixel_port_clut_bench.sv
`timescale 1ns/1ps
module pixel_port_clut_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux2_en = 1'b0;
    logic [1:0] fmt = 2'd0, pseudo_src = 2'd0, ps_match = 2'd0;
    logic       sync_en = 1'b0;
    logic [7:0] pix_mask = 8'hFF;
    logic [7:0] a_r = 0, a_g = 0, a_b = 0, b_r = 0, b_g = 0, b_b = 0;
    logic [1:0] a_ps = 0, b_ps = 0;
    logic       a_sync = 0, a_blank = 0, b_sync = 0, b_blank = 0;
    logic       load_strobe;
    logic       lut_we = 1'b0;
    logic [1:0] lut_sel = 2'd0;
    logic [7:0] lut_addr = 8'd0;
    logic [9:0] lut_wdata = 10'd0;
    logic [9:0] out_r, out_g, out_b;
    logic       sync_out, sync_lvl;

    always #5 clk = ~clk;

    pixel_port_clut u_pixel_port_clut (.*);

    int n_chk = 0;
    int n_fail = 0;
    int ecount = 0;
    bit sched_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    logic [9:0] lm [3][256];
    logic [9:0] e_col [16][3];
    logic       e_sync [16];
    logic       e_lvl [16];
    bit         e_vld [16];
    string      e_tag [16];

    function automatic logic [9:0] lut_val(int ch, int a);
        return {1'b1, 9'((a * 37 + ch * 211 + 5) % 512)};
    endfunction

    // model of the index formation: R3 direct, R4 15-bit, R5 indexed, R6 mask
    function automatic logic [7:0] model_idx(int ch, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        logic [7:0] c, s;
        c = (ch == 0) ? r : (ch == 1) ? g : b;
        s = (pseudo_src == 2'd0) ? r : (pseudo_src == 2'd1) ? g : b;
        case (fmt)
            2'd1:    c = {c[7:3], 3'b000};
            2'd2:    c = s;
            default: c = c;
        endcase
        return c & pix_mask;
    endfunction

    task automatic schedule(int edge_n, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                            logic [1:0] ps, logic sy, logic bl);
        int k;
        k = edge_n % 16;
        for (int ch = 0; ch < 3; ch++) begin
            e_col[k][ch] = (bl || ps != ps_match) ? 10'd0 : lm[ch][model_idx(ch, r, g, b)];
        end
        e_sync[k] = sy;
        e_lvl[k]  = sy & sync_en;
        e_vld[k]  = 1'b1;
        if (bl)                 e_tag[k] = "R8";
        else if (ps != ps_match) e_tag[k] = "R7";
        else if (fmt == 2'd1)   e_tag[k] = "R4";
        else if (fmt == 2'd2)   e_tag[k] = "R5";
        else                    e_tag[k] = "R3";
        if (pix_mask != 8'hFF)  e_tag[k] = {e_tag[k], " R6"};
    endtask

    task automatic check_due();
        int k;
        k = ecount % 16;
        if (e_vld[k]) begin
            n_chk++;
            if ({out_r, out_g, out_b} !== {e_col[k][0], e_col[k][1], e_col[k][2]}) begin
                n_fail++;
                $display("FAIL R2 %s colour at edge %0d: got %h/%h/%h expected %h/%h/%h", e_tag[k],
                         ecount, out_r, out_g, out_b, e_col[k][0], e_col[k][1], e_col[k][2]);
            end
            n_chk++;
            if (sync_out !== e_sync[k]) begin
                n_fail++;
                $display("FAIL R9 sync_out at edge %0d: got %b expected %b", ecount, sync_out, e_sync[k]);
            end
            n_chk++;
            if (sync_lvl !== e_lvl[k]) begin
                n_fail++;
                $display("FAIL R10 sync_lvl at edge %0d: got %b expected %b", ecount, sync_lvl, e_lvl[k]);
            end
            e_vld[k] = 1'b0;
        end
    endtask

    task automatic step();
        logic cap;
        int lat;
        @(negedge clk);
        check_due();
        cap = !mux2_en || (ecount % 2 == 0);
        n_chk++;
        if (load_strobe !== cap) begin
            n_fail++;
            $display("FAIL R1 load_strobe at edge %0d: got %b expected %b", ecount, load_strobe, cap);
        end
        a_r = 8'($urandom); a_g = 8'($urandom); a_b = 8'($urandom);
        b_r = 8'($urandom); b_g = 8'($urandom); b_b = 8'($urandom);
        a_ps = ($urandom % 4 == 0) ? 2'($urandom) : ps_match;
        b_ps = ($urandom % 4 == 0) ? 2'($urandom) : ps_match;
        a_sync = ($urandom % 4 == 0); b_sync = ($urandom % 4 == 0);
        a_blank = ($urandom % 8 == 0); b_blank = ($urandom % 8 == 0);
        if (sched_en && cap) begin
            lat = mux2_en ? 6 : 5;
            schedule(ecount + 1 + lat, a_r, a_g, a_b, a_ps, a_sync, a_blank);
            if (mux2_en)
                schedule(ecount + 2 + lat, b_r, b_g, b_b, b_ps, b_sync, b_blank);
        end
    endtask

    task automatic run(logic m2, logic [1:0] f, logic [1:0] src, logic [1:0] psm,
                       logic sen, logic [7:0] msk, int n);
        @(negedge clk);
        rst_n = 1'b0;
        mux2_en = m2; fmt = f; pseudo_src = src; ps_match = psm; sync_en = sen; pix_mask = msk;
        for (int i = 0; i < 16; i++) e_vld[i] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if ({out_r, out_g, out_b, sync_out, sync_lvl} !== '0 || load_strobe !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 reset state: got %h/%h/%h s%b l%b ld%b expected 0/0/0 s0 l0 ld1",
                     out_r, out_g, out_b, sync_out, sync_lvl, load_strobe);
        end
        rst_n = 1'b1;
        sched_en = 1'b1;
        for (int i = 0; i < n; i++) step();
        sched_en = 1'b0;
        for (int i = 0; i < 10; i++) step();
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int ch = 0; ch < 3; ch++)
            for (int a = 0; a < 256; a++)
                lm[ch][a] = lut_val(ch, a);
        // load the three tables while reset is held
        for (int ch = 0; ch < 3; ch++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                lut_we = 1'b1; lut_sel = 2'(ch); lut_addr = 8'(a); lut_wdata = lm[ch][a];
            end
        end
        @(negedge clk);
        lut_we = 1'b0;

        run(1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 8'hFF, 60);   // single, direct 24
        run(1'b1, 2'd0, 2'd0, 2'd2, 1'b0, 8'hFF, 60);   // pair, direct 24
        run(1'b1, 2'd1, 2'd0, 2'd1, 1'b1, 8'hFF, 60);   // pair, 15-bit
        run(1'b0, 2'd2, 2'd0, 2'd0, 1'b1, 8'h3C, 60);   // indexed from red, masked
        run(1'b1, 2'd2, 2'd1, 2'd3, 1'b0, 8'hFF, 60);   // indexed from green
        run(1'b0, 2'd2, 2'd2, 2'd3, 1'b1, 8'hFF, 60);   // indexed from blue
        run(1'b1, 2'd2, 2'd3, 2'd0, 1'b1, 8'hF0, 60);   // source code 3 -> blue
        run(1'b0, 2'd3, 2'd0, 2'd1, 1'b0, 8'h00, 40);   // spare format, mask zero
        run(1'b1, 2'd1, 2'd0, 2'd2, 1'b1, 8'h81, 40);   // 15-bit, sparse mask

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule